// File: doc/BRIEF.md
# Platform Power State Controller

This block is a synchronous state machine that follows the platform's combined power condition: five processor-idle levels while working (C0 to C4), one sleeping state whose depth is carried in a separate sleep-type field, soft-off, and mechanical-off. It consumes single-cycle event strobes from the rest of the chip (halt, idle-level reads, the sleep-enable write, break and wake events, bus-master activity and idleness, a clock-stop request, the power-button override, power failure and power return). It also takes a battery-low level and a handful of configuration bits.

The controller only decides which state the platform is in. It publishes that state as a registered one-hot vector together with the latched sleep type, and other logic acts on them. The deep idle levels can drop back into one another or pop up to C2 depending on bus-master traffic. Any return to working from sleep, soft-off or mechanical-off waits while the battery is low. Power failure always ends in mechanical-off.

Top module: `pwr_state_ctrl`

## Requirements
- R1: Reset places the machine in mechanical-off with sleep type zero. The output `stateOh` always has exactly one bit set, at these positions: bit 0 C0, bit 1 C1, bit 2 C2, bit 3 C3, bit 4 C4, bit 5 sleeping, bit 6 soft-off, bit 7 mechanical-off. Every transition shows on `stateOh` one clock after the event is sampled.
- R2: In C0, halt goes to C1, a level-2 read goes to C2 and a level-4 read goes to C4. When several of these arrive together, the order of precedence is sleep-enable, then level-4, then level-3, then level-2, then halt.
- R3: In C0, a level-3 read goes to C2 when the bus-master-zero enable is set and a bus-master strobe arrives in the same cycle. Otherwise it goes to C4 when the C4-on-C3 bit is set, and to C3 when it is clear.
- R4: In C0, sleep-enable goes to soft-off when `cfgSleepType` is all ones. For any other value it goes to the sleeping state and copies `cfgSleepType` into `sleepType`. `sleepType` holds its value at all other times.
- R5: In C1, break returns to C0. A clock-stop request without a break goes to C2.
- R6: In C2, break returns to C0. Bus-masters-idle goes to C4 if the deep-idle bit is set and to C3 if it is clear, but only when C3 or C4 was visited since C0 was last entered.
- R7: In C3 or C4, break returns to C0. A bus-master strobe without a break goes to C2 when the pop-up bit is set and to C0 when it is clear.
- R8: In C3, bus-masters-idle goes to C4 when C4 was visited since C0 was last entered and the deep-idle bit is set. Otherwise it has no effect.
- R9: The record of visited deep idle levels is cleared on every entry to C0. After that, bus-masters-idle in C2 has no effect.
- R10: In the sleeping state or soft-off, a wake strobe goes to C0. A wake strobe in any working state has no effect.
- R11: While battery-low is high, a transition to C0 out of sleeping, soft-off or mechanical-off does not happen. The request is latched instead, and C0 is entered on the first clock edge at which battery-low is low.
- R12: The power-button override goes to soft-off from any working or sleeping state and outranks every event except power failure. It has no effect in mechanical-off.
- R13: Power failure goes to mechanical-off from every state and outranks every other event.
- R14: In mechanical-off, power return goes to C0 when the auto-on bit is set and to soft-off when it is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| evHalt | input | 1 | Processor halt strobe |
| evLvl2 | input | 1 | Level-2 idle read strobe |
| evLvl3 | input | 1 | Level-3 idle read strobe |
| evLvl4 | input | 1 | Level-4 idle read strobe |
| evSleepEn | input | 1 | Sleep-enable write strobe |
| evBreak | input | 1 | Enabled break event strobe |
| evWake | input | 1 | Enabled wake event strobe |
| evBusMaster | input | 1 | Bus-master activity strobe |
| evBmIdle | input | 1 | Bus masters idle strobe |
| evClkStop | input | 1 | Clock-stop request strobe |
| evPwrBtnOvr | input | 1 | Power-button override strobe |
| evPwrFail | input | 1 | Power failure strobe |
| evPwrReturn | input | 1 | Power return strobe |
| batLow | input | 1 | Battery-low level |
| cfgC4OnC3 | input | 1 | Level-3 read selects C4 |
| cfgBmZeroEn | input | 1 | Bus activity turns a level-3 read into C2 |
| cfgDeepIdle | input | 1 | Re-entry from bus-masters-idle selects C4 |
| cfgPopUp | input | 1 | Bus activity in C3/C4 goes to C2 instead of C0 |
| cfgAutoOn | input | 1 | Power return goes to C0 instead of soft-off |
| cfgSleepType | input | SLP_TYPE_W | Programmed sleep type (all ones means soft-off) |
| stateOh | output | 8 | One-hot current state |
| sleepType | output | SLP_TYPE_W | Sleep type latched on entry to sleeping |

## Verification
The bench builds the block with the default 3-bit sleep type, so all eight sleep-type codes can be swept, including the all-ones code that selects soft-off. The state set is small enough that power failure and the power-button override are applied from every one of the eight states. The 31 combinations of the C0 entry strobes are applied, and so are all eight combinations of the level-3 selection inputs. The deep-idle re-entry paths are driven through sequences that first visit C3 or C4, and the battery-low deferral is checked from both sleeping and mechanical-off.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;

  typedef enum logic [2:0] {
    PS_C0      = 3'd0,
    PS_C1      = 3'd1,
    PS_C2      = 3'd2,
    PS_C3      = 3'd3,
    PS_C4      = 3'd4,
    PS_SLEEP   = 3'd5,
    PS_SOFTOFF = 3'd6,
    PS_MECHOFF = 3'd7
  } pstate_t;

  localparam int unsigned NUM_PSTATES = 8;

  // deepest idle level visited since the last entry to C0
  typedef enum logic [1:0] {
    DEEP_NONE = 2'd0,
    DEEP_C3   = 2'd1,
    DEEP_C4   = 2'd2
  } deep_t;

  typedef struct packed {
    logic halt;
    logic lvl2;
    logic lvl3;
    logic lvl4;
    logic sleepEn;
    logic brk;
    logic wake;
    logic busMaster;
    logic bmIdle;
    logic clkStop;
    logic btnOvr;
    logic pwrFail;
    logic pwrReturn;
  } pwr_events_t;

  typedef struct packed {
    logic c4OnC3;
    logic bmZeroEn;
    logic deepIdle;
    logic popUp;
    logic autoOn;
  } pwr_cfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic    trans;
    pstate_t next;
    logic    armWake;
    logic    captureType;
  } ctl_strobe_t;

endpackage

// File: rtl/pwr_state_ctl.sv
module pwr_state_ctl
  import pwr_state_pkg::*;
#(
  parameter int unsigned SLP_TYPE_W = 3
) (
  input  pstate_t               curState,
  input  deep_t                 deepSeen,
  input  logic                  wakePending,
  input  pwr_events_t           ev,
  input  pwr_cfg_t              cfg,
  input  logic                  batLow,
  input  logic [SLP_TYPE_W-1:0] cfgSleepType,
  output ctl_strobe_t           strobe
);

  localparam logic [SLP_TYPE_W-1:0] SOFT_OFF_CODE = {SLP_TYPE_W{1'b1}};

  pstate_t nextState;
  logic    armWake;
  logic    captureType;
  logic    wakeReq;

  assign wakeReq = ev.wake || wakePending;

  always_comb begin
    nextState   = curState;
    armWake     = 1'b0;
    captureType = 1'b0;
    if (ev.pwrFail) begin
      nextState = PS_MECHOFF;
    end else if (ev.btnOvr && curState != PS_MECHOFF) begin
      nextState = PS_SOFTOFF;
    end else begin
      unique case (curState)
        PS_C0: begin
          if (ev.sleepEn) begin
            if (cfgSleepType == SOFT_OFF_CODE) begin
              nextState = PS_SOFTOFF;
            end else begin
              nextState   = PS_SLEEP;
              captureType = 1'b1;
            end
          end else if (ev.lvl4) begin
            nextState = PS_C4;
          end else if (ev.lvl3) begin
            if (cfg.bmZeroEn && ev.busMaster) nextState = PS_C2;
            else if (cfg.c4OnC3)               nextState = PS_C4;
            else                               nextState = PS_C3;
          end else if (ev.lvl2) begin
            nextState = PS_C2;
          end else if (ev.halt) begin
            nextState = PS_C1;
          end
        end
        PS_C1: begin
          if (ev.brk)          nextState = PS_C0;
          else if (ev.clkStop) nextState = PS_C2;
        end
        PS_C2: begin
          if (ev.brk) begin
            nextState = PS_C0;
          end else if (ev.bmIdle && deepSeen != DEEP_NONE) begin
            nextState = cfg.deepIdle ? PS_C4 : PS_C3;
          end
        end
        PS_C3: begin
          if (ev.brk) begin
            nextState = PS_C0;
          end else if (ev.busMaster) begin
            nextState = cfg.popUp ? PS_C2 : PS_C0;
          end else if (ev.bmIdle && deepSeen == DEEP_C4 && cfg.deepIdle) begin
            nextState = PS_C4;
          end
        end
        PS_C4: begin
          if (ev.brk)            nextState = PS_C0;
          else if (ev.busMaster) nextState = cfg.popUp ? PS_C2 : PS_C0;
        end
        PS_SLEEP, PS_SOFTOFF: begin
          if (wakeReq) begin
            if (batLow) armWake   = 1'b1;
            else        nextState = PS_C0;
          end
        end
        PS_MECHOFF: begin
          if (wakePending) begin
            if (!batLow) nextState = PS_C0;
          end else if (ev.pwrReturn) begin
            if (!cfg.autoOn)  nextState = PS_SOFTOFF;
            else if (batLow)  armWake   = 1'b1;
            else              nextState = PS_C0;
          end
        end
        default: nextState = PS_MECHOFF;
      endcase
    end
  end

  always_comb begin
    strobe.trans       = (nextState != curState);
    strobe.next        = nextState;
    strobe.armWake     = armWake;
    strobe.captureType = captureType;
  end

endmodule

// File: rtl/pwr_state_dp.sv
module pwr_state_dp
  import pwr_state_pkg::*;
#(
  parameter int unsigned SLP_TYPE_W = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctl_strobe_t           strobe,
  input  logic [SLP_TYPE_W-1:0] cfgSleepType,
  output pstate_t               curState,
  output deep_t                 deepSeen,
  output logic                  wakePending,
  output logic [NUM_PSTATES-1:0] stateOh,
  output logic [SLP_TYPE_W-1:0] sleepType
);

  pstate_t               stateQ;
  deep_t                 deepQ;
  logic                  pendQ;
  logic [SLP_TYPE_W-1:0] typeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= PS_MECHOFF;
      deepQ  <= DEEP_NONE;
      pendQ  <= 1'b0;
      typeQ  <= '0;
    end else begin
      if (strobe.trans) begin
        stateQ <= strobe.next;
        pendQ  <= 1'b0;
        if (strobe.next == PS_C0)                           deepQ <= DEEP_NONE;
        else if (strobe.next == PS_C4)                      deepQ <= DEEP_C4;
        else if (strobe.next == PS_C3 && deepQ != DEEP_C4)  deepQ <= DEEP_C3;
      end else if (strobe.armWake) begin
        pendQ <= 1'b1;
      end
      if (strobe.captureType) typeQ <= cfgSleepType;
    end
  end

  for (genvar i = 0; i < NUM_PSTATES; i++) begin : g_oh
    assign stateOh[i] = (int'(stateQ) == i);
  end

  assign curState    = stateQ;
  assign deepSeen    = deepQ;
  assign wakePending = pendQ;
  assign sleepType   = typeQ;

endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import pwr_state_pkg::*;
#(
  parameter int unsigned SLP_TYPE_W = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   evHalt,
  input  logic                   evLvl2,
  input  logic                   evLvl3,
  input  logic                   evLvl4,
  input  logic                   evSleepEn,
  input  logic                   evBreak,
  input  logic                   evWake,
  input  logic                   evBusMaster,
  input  logic                   evBmIdle,
  input  logic                   evClkStop,
  input  logic                   evPwrBtnOvr,
  input  logic                   evPwrFail,
  input  logic                   evPwrReturn,
  input  logic                   batLow,
  input  logic                   cfgC4OnC3,
  input  logic                   cfgBmZeroEn,
  input  logic                   cfgDeepIdle,
  input  logic                   cfgPopUp,
  input  logic                   cfgAutoOn,
  input  logic [SLP_TYPE_W-1:0]  cfgSleepType,
  output logic [NUM_PSTATES-1:0] stateOh,
  output logic [SLP_TYPE_W-1:0]  sleepType
);

  pwr_events_t ev;
  pwr_cfg_t    cfg;
  ctl_strobe_t strobe;
  pstate_t     curState;
  deep_t       deepSeen;
  logic        wakePending;

  always_comb begin
    ev.halt      = evHalt;
    ev.lvl2      = evLvl2;
    ev.lvl3      = evLvl3;
    ev.lvl4      = evLvl4;
    ev.sleepEn   = evSleepEn;
    ev.brk       = evBreak;
    ev.wake      = evWake;
    ev.busMaster = evBusMaster;
    ev.bmIdle    = evBmIdle;
    ev.clkStop   = evClkStop;
    ev.btnOvr    = evPwrBtnOvr;
    ev.pwrFail   = evPwrFail;
    ev.pwrReturn = evPwrReturn;
    cfg.c4OnC3   = cfgC4OnC3;
    cfg.bmZeroEn = cfgBmZeroEn;
    cfg.deepIdle = cfgDeepIdle;
    cfg.popUp    = cfgPopUp;
    cfg.autoOn   = cfgAutoOn;
  end

  pwr_state_ctl #(.SLP_TYPE_W(SLP_TYPE_W)) u_ctl (
    .curState     (curState),
    .deepSeen     (deepSeen),
    .wakePending  (wakePending),
    .ev           (ev),
    .cfg          (cfg),
    .batLow       (batLow),
    .cfgSleepType (cfgSleepType),
    .strobe       (strobe)
  );

  pwr_state_dp #(.SLP_TYPE_W(SLP_TYPE_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .cfgSleepType (cfgSleepType),
    .curState     (curState),
    .deepSeen     (deepSeen),
    .wakePending  (wakePending),
    .stateOh      (stateOh),
    .sleepType    (sleepType)
  );

endmodule

// File: rtl/pwr_state_ctrl_chk.sv
module pwr_state_ctrl_chk #(
  parameter int unsigned SLP_TYPE_W = 3
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  evBreak,
  input logic                  evWake,
  input logic                  evPwrBtnOvr,
  input logic                  evPwrFail,
  input logic                  batLow,
  input logic [SLP_TYPE_W-1:0] cfgSleepType,
  input logic [7:0]            stateOh,
  input logic [SLP_TYPE_W-1:0] sleepType
);

  AST_ONE_STATE: assert property (@(posedge clk) disable iff (!rstN)
    $countones(stateOh) == 1); // R1

  AST_FAIL_TO_MECHOFF: assert property (@(posedge clk) disable iff (!rstN)
    evPwrFail |=> stateOh[7]); // R13

  AST_OVR_TO_SOFTOFF: assert property (@(posedge clk) disable iff (!rstN)
    (!evPwrFail && evPwrBtnOvr && !stateOh[7]) |=> stateOh[6]); // R12

  AST_BREAK_TO_C0: assert property (@(posedge clk) disable iff (!rstN)
    (!evPwrFail && !evPwrBtnOvr && evBreak && (|stateOh[4:1])) |=> stateOh[0]); // R5

  AST_WAKE_TO_C0: assert property (@(posedge clk) disable iff (!rstN)
    (!evPwrFail && !evPwrBtnOvr && !batLow && evWake && (stateOh[5] || stateOh[6]))
      |=> stateOh[0]); // R10

  AST_BATLOW_DEFER: assert property (@(posedge clk) disable iff (!rstN)
    (batLow && (|stateOh[7:5])) |=> !stateOh[0]); // R11

  AST_TYPE_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stateOh[5]) |-> sleepType == $past(cfgSleepType)); // R4

endmodule

bind pwr_state_ctrl pwr_state_ctrl_chk #(.SLP_TYPE_W(SLP_TYPE_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .evBreak      (evBreak),
  .evWake       (evWake),
  .evPwrBtnOvr  (evPwrBtnOvr),
  .evPwrFail    (evPwrFail),
  .batLow       (batLow),
  .cfgSleepType (cfgSleepType),
  .stateOh      (stateOh),
  .sleepType    (sleepType)
);

// File: tb/tb_pwr_state_ctrl.sv
`timescale 1ns/1ps
module tb_pwr_state_ctrl;

  localparam int C0 = 0, C1 = 1, C2 = 2, C3 = 3, C4 = 4, SLP = 5, SOFF = 6, MOFF = 7;
  localparam int E_HALT = 0, E_L2 = 1, E_L3 = 2, E_L4 = 3, E_SLP = 4, E_BRK = 5,
                 E_WAKE = 6, E_BM = 7, E_BMIDLE = 8, E_CLKSTOP = 9, E_OVR = 10,
                 E_FAIL = 11, E_RET = 12;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [12:0] ev = '0;
  logic        batLow = 1'b0;
  logic        cfgC4OnC3 = 1'b0, cfgBmZeroEn = 1'b0, cfgDeepIdle = 1'b0;
  logic        cfgPopUp = 1'b0, cfgAutoOn = 1'b1;
  logic [2:0]  cfgSleepType = 3'd3;
  logic [7:0]  stateOh;
  logic [2:0]  sleepType;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [2:0] expType = 3'd0;

  always #5 clk = ~clk;

  pwr_state_ctrl #(.SLP_TYPE_W(3)) dut (
    .clk(clk), .rstN(rstN),
    .evHalt(ev[E_HALT]), .evLvl2(ev[E_L2]), .evLvl3(ev[E_L3]), .evLvl4(ev[E_L4]),
    .evSleepEn(ev[E_SLP]), .evBreak(ev[E_BRK]), .evWake(ev[E_WAKE]),
    .evBusMaster(ev[E_BM]), .evBmIdle(ev[E_BMIDLE]), .evClkStop(ev[E_CLKSTOP]),
    .evPwrBtnOvr(ev[E_OVR]), .evPwrFail(ev[E_FAIL]), .evPwrReturn(ev[E_RET]),
    .batLow(batLow), .cfgC4OnC3(cfgC4OnC3), .cfgBmZeroEn(cfgBmZeroEn),
    .cfgDeepIdle(cfgDeepIdle), .cfgPopUp(cfgPopUp), .cfgAutoOn(cfgAutoOn),
    .cfgSleepType(cfgSleepType), .stateOh(stateOh), .sleepType(sleepType)
  );

  function automatic logic [12:0] bitOf(int e);
    return 13'(1) << e;
  endfunction

  // drive strobes for one cycle; sample 1 ns after the edge
  task automatic step(logic [12:0] e);
    ev = e;
    @(posedge clk);
    #1;
    ev = '0;
  endtask

  task automatic chk(string req, int expIdx);
    logic [7:0] expOh;
    expOh = 8'(1) << expIdx;
    checks++;
    if (stateOh !== expOh) begin
      fails++;
      $display("FAIL %s: stateOh=%b expected=%b", req, stateOh, expOh);
    end
  endtask

  task automatic chkType(string req, logic [2:0] expVal);
    checks++;
    if (sleepType !== expVal) begin
      fails++;
      $display("FAIL %s: sleepType=%0d expected=%0d", req, sleepType, expVal);
    end
  endtask

  task automatic goTo(int s);
    batLow = 1'b0; cfgAutoOn = 1'b1; cfgC4OnC3 = 1'b0; cfgBmZeroEn = 1'b0;
    cfgDeepIdle = 1'b0; cfgPopUp = 1'b0; cfgSleepType = 3'd3;
    step(bitOf(E_FAIL));
    if (s == MOFF) return;
    step(bitOf(E_RET));
    case (s)
      C1:   step(bitOf(E_HALT));
      C2:   step(bitOf(E_L2));
      C3:   step(bitOf(E_L3));
      C4:   step(bitOf(E_L4));
      SLP:  begin step(bitOf(E_SLP)); expType = 3'd3; end
      SOFF: begin cfgSleepType = 3'd7; step(bitOf(E_SLP)); cfgSleepType = 3'd3; end
      default: ;
    endcase
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 reset state", MOFF);
    chkType("R1 reset sleep type", 3'd0);
    rstN = 1'b1;
    @(posedge clk); #1;
    chk("R1 idle after reset", MOFF);

    // R13: power failure wins from every state
    for (int s = 0; s < 8; s++) begin
      goTo(s);
      step(bitOf(E_FAIL) | bitOf(E_OVR) | bitOf(E_BRK) | bitOf(E_WAKE) | bitOf(E_L2));
      chk("R13 fail from any state", MOFF);
    end

    // R12: override to soft-off from working/sleeping, ignored in mechanical-off
    for (int s = 0; s < 8; s++) begin
      goTo(s);
      step(bitOf(E_OVR) | bitOf(E_BRK) | bitOf(E_WAKE) | bitOf(E_HALT));
      chk("R12 override", (s == MOFF) ? MOFF : SOFF);
    end

    // R2: every combination of C0 entry strobes, precedence order
    for (int m = 1; m < 32; m++) begin
      int expS;
      goTo(C0);
      expS = m[4] ? SLP : m[3] ? C4 : m[2] ? C3 : m[1] ? C2 : C1;
      step(13'(m));
      chk("R2 C0 entry precedence", expS);
    end

    // R3: level-3 selection sweep
    for (int m = 0; m < 8; m++) begin
      int expS;
      goTo(C0);
      cfgC4OnC3 = m[0]; cfgBmZeroEn = m[1];
      expS = (m[1] && m[2]) ? C2 : (m[0] ? C4 : C3);
      step(bitOf(E_L3) | (m[2] ? bitOf(E_BM) : 13'd0));
      chk("R3 level-3 selection", expS);
    end

    // R4: sleep type sweep, all-ones selects soft-off, type held otherwise
    for (int t = 0; t < 8; t++) begin
      goTo(C0);
      cfgSleepType = 3'(t);
      step(bitOf(E_SLP));
      if (t == 7) begin
        chk("R4 all-ones type to soft-off", SOFF);
      end else begin
        chk("R4 sleep entry", SLP);
        expType = 3'(t);
      end
      chkType("R4 latched sleep type", expType);
      cfgSleepType = 3'(t + 1);
      step('0);
      chkType("R4 sleep type held", expType);
    end

    // R5: C1 exits
    goTo(C1); step(bitOf(E_BRK));                      chk("R5 C1 break", C0);
    goTo(C1); step(bitOf(E_CLKSTOP));                  chk("R5 C1 clock stop", C2);
    goTo(C1); step(bitOf(E_CLKSTOP) | bitOf(E_BRK));   chk("R5 C1 break over stop", C0);

    // R6: C2 re-entry after a deep visit, per deep-idle bit
    for (int d = 0; d < 2; d++) begin
      goTo(C3);
      cfgPopUp = 1'b1; cfgDeepIdle = d[0];
      step(bitOf(E_BM));     chk("R6 pop-up from C3", C2);
      step(bitOf(E_BMIDLE)); chk("R6 C2 deep re-entry", d[0] ? C4 : C3);
    end
    goTo(C2); step(bitOf(E_BRK)); chk("R6 C2 break", C0);

    // R9: record cleared on C0 entry
    goTo(C4);
    cfgDeepIdle = 1'b1;
    step(bitOf(E_BRK));    chk("R9 back to C0", C0);
    step(bitOf(E_L2));     chk("R9 C2 via level-2", C2);
    step(bitOf(E_BMIDLE)); chk("R9 bus idle ignored in C2", C2);

    // R7: bus-master and break exits from C3 and C4
    for (int m = 0; m < 4; m++) begin
      goTo(m[0] ? C4 : C3);
      cfgPopUp = m[1];
      step(bitOf(E_BM));
      chk("R7 bus-master exit", m[1] ? C2 : C0);
      goTo(m[0] ? C4 : C3);
      cfgPopUp = m[1];
      step(bitOf(E_BM) | bitOf(E_BRK));
      chk("R7 break over bus-master", C0);
    end

    // R8: C3 to C4 after a prior C4
    goTo(C4);
    cfgPopUp = 1'b1; cfgDeepIdle = 1'b0;
    step(bitOf(E_BM));     chk("R8 pop-up from C4", C2);
    step(bitOf(E_BMIDLE)); chk("R8 down to C3", C3);
    cfgDeepIdle = 1'b1;
    step(bitOf(E_BMIDLE)); chk("R8 C3 to C4", C4);
    goTo(C3);
    cfgDeepIdle = 1'b1;
    step(bitOf(E_BMIDLE)); chk("R8 no prior C4, stay C3", C3);

    // R10: wake
    goTo(SLP);  step(bitOf(E_WAKE)); chk("R10 wake from sleep", C0);
    goTo(SOFF); step(bitOf(E_WAKE)); chk("R10 wake from soft-off", C0);
    goTo(C1);   step(bitOf(E_WAKE)); chk("R10 wake ignored in C1", C1);
    goTo(C0);   step(bitOf(E_WAKE)); chk("R10 wake ignored in C0", C0);

    // R11: deferred wake
    goTo(SLP);
    batLow = 1'b1;
    step(bitOf(E_WAKE)); chk("R11 wake deferred", SLP);
    step('0);            chk("R11 still deferred", SLP);
    batLow = 1'b0;
    #2;                  chk("R11 no change before edge", SLP);
    step('0);            chk("R11 latched wake completes", C0);

    // R14: power return
    goTo(MOFF); cfgAutoOn = 1'b0; step(bitOf(E_RET)); chk("R14 return to soft-off", SOFF);
    goTo(MOFF); cfgAutoOn = 1'b1; step(bitOf(E_RET)); chk("R14 return to C0", C0);
    goTo(MOFF); cfgAutoOn = 1'b1; batLow = 1'b1;
    step(bitOf(E_RET)); chk("R11 return deferred", MOFF);
    batLow = 1'b0;
    step('0);           chk("R14 deferred return completes", C0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule